// File: doc/BRIEF.md
# Reset Cause Status and Resume Vector Unit

This block keeps a record of why a small processor core last left reset or sleep. Single-cycle event strobes arrive from the reset, watchdog and interrupt logic around it: power-on, master clear while running, master clear while asleep, watchdog expiry while running, watchdog expiry while asleep, and interrupt wake-up. The block updates two status flags from these strobes. The time-out flag (`to_flag`) reads 0 after a watchdog expiry. The power-down flag (`pd_flag`) reads 0 after sleep was entered. The block also keeps three bank/page select bits and computes the program-counter value the core resumes from.

The two flags are held as the state of a four-state machine. The states are `ST_CLEAN` (TO=1, PD=1), `ST_WDT_RST` (TO=0, PD=1), `ST_DOWN` (TO=1, PD=0) and `ST_WDT_WAKE` (TO=0, PD=0). The next state follows only from the winning event:

- power-on, master clear while running and the watchdog-clear strobe go to `ST_CLEAN`.
- watchdog expiry while running goes to `ST_WDT_RST`.
- master clear while asleep, interrupt wake-up and the sleep-entry strobe go to `ST_DOWN`.
- watchdog expiry while asleep goes to `ST_WDT_WAKE`.
- with no event, the machine stays where it is.

The core also supplies its current program counter, the global interrupt enable, and a write port for the bank bits. One cycle after each reset or wake-up event, `pc_load` pulses and `pc_next` carries the resume address.

Top module: `rst_cause_unit`

## Requirements
- R1: While `rst_n` is low, and one cycle after `ev_por`, TO=1, PD=1 and bank bits are 000. After `ev_por`, `pc_load` pulses with `pc_next`=0. Directly after `rst_n` release, `pc_load`=0 and `pc_next`=0.
- R2: One cycle after `ev_mclr_run`: TO=1, PD=1, bank bits 000, `pc_load`=1 and `pc_next`=0.
- R3: One cycle after `ev_mclr_slp`: TO=1, PD=0, bank bits 000, `pc_load`=1 and `pc_next`=0.
- R4: One cycle after `ev_wdt_run`: TO=0, PD=1, bank bits 000, `pc_load`=1 and `pc_next`=0.
- R5: One cycle after `ev_wdt_slp`: TO=0, PD=0, bank bits unchanged, `pc_load`=1 and `pc_next`=`cur_pc`+1.
- R6: One cycle after `ev_irq_wake` with `gie`=0: TO=1, PD=0, bank bits unchanged, `pc_load`=1 and `pc_next`=`cur_pc`+1.
- R7: One cycle after `ev_irq_wake` with `gie`=1: `pc_next`=0x004, with flags and bank bits as in R6.
- R8: `ev_sleep` gives TO=1, PD=0. `ev_wdt_clr` gives TO=1, PD=1. Neither strobe changes the bank bits or raises `pc_load`.
- R9: When strobes coincide, one event wins. The order is power-on, then master clear (run before sleep), then watchdog (run before sleep), then interrupt wake-up, then sleep entry, then watchdog clear.
- R10: `bank_we` loads `bank_wdata` into the bank bits one cycle later. Any event in the same cycle takes precedence over the write, so the write is dropped.
- R11: `cur_pc`+1 wraps modulo 2^PC_W, so an all-ones `cur_pc` resumes at 0.
- R12: `pc_load` is high only in the cycle after a reset or wake-up event. With no event, the flags and `pc_next` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, same effect as power-on |
| ev_por | input | 1 | Power-on reset strobe |
| ev_mclr_run | input | 1 | Master clear while running |
| ev_mclr_slp | input | 1 | Master clear while asleep |
| ev_wdt_run | input | 1 | Watchdog expiry while running |
| ev_wdt_slp | input | 1 | Watchdog expiry while asleep |
| ev_irq_wake | input | 1 | Interrupt wake-up from sleep |
| ev_sleep | input | 1 | Sleep entry strobe |
| ev_wdt_clr | input | 1 | Watchdog clear strobe |
| gie | input | 1 | Global interrupt enable |
| cur_pc | input | PC_W (13) | Current program counter |
| bank_we | input | 1 | Bank bits write enable |
| bank_wdata | input | BANK_W (3) | Bank bits write data |
| to_flag | output | 1 | Time-out flag (0 after watchdog expiry) |
| pd_flag | output | 1 | Power-down flag (0 after sleep entry) |
| bank_bits | output | BANK_W (3) | Bank/page select bits |
| pc_load | output | 1 | Resume address valid, one cycle |
| pc_next | output | PC_W (13) | Resume address |

## Verification
The hardest situations to reach from the ports are the wake-up events that must leave the bank bits untouched. A cleared value would look the same as a kept one, so the bench first writes a nonzero pattern through the write port. It then enters sleep and fires the wake-up. The priority order is driven by raising pairs of strobes in one cycle, each pair chosen so that the two candidate outcomes differ in flags, bank bits or resume address. The wrap of the resume address is reached by presenting an all-ones program counter with a watchdog wake-up.

// File: rtl/rcu_pkg.sv
package rcu_pkg;

    // Number of event strobes, index order is priority order (0 wins)
    localparam int NUM_EV = 8;

    typedef enum logic [3:0] {
        EV_NONE     = 4'd0,
        EV_POR      = 4'd1,
        EV_MCLR_RUN = 4'd2,
        EV_MCLR_SLP = 4'd3,
        EV_WDT_RUN  = 4'd4,
        EV_WDT_SLP  = 4'd5,
        EV_IRQ      = 4'd6,
        EV_SLEEP    = 4'd7,
        EV_WCLR     = 4'd8
    } rcu_ev_e;

    // State encoding equals {to, pd}
    typedef enum logic [1:0] {
        ST_WDT_WAKE = 2'b00,
        ST_WDT_RST  = 2'b01,
        ST_DOWN     = 2'b10,
        ST_CLEAN    = 2'b11
    } rcu_state_e;

    function automatic logic ev_clears_bank(input rcu_ev_e ev);
        return (ev == EV_POR) || (ev == EV_MCLR_RUN) ||
               (ev == EV_MCLR_SLP) || (ev == EV_WDT_RUN);
    endfunction

    function automatic logic ev_is_wake(input rcu_ev_e ev);
        return (ev == EV_WDT_SLP) || (ev == EV_IRQ);
    endfunction

    function automatic logic ev_loads_pc(input rcu_ev_e ev);
        return ev_clears_bank(ev) || ev_is_wake(ev);
    endfunction

endpackage

// File: rtl/rcu_arbiter.sv
module rcu_arbiter
    import rcu_pkg::*;
(
    input  logic [NUM_EV-1:0] req,
    output rcu_ev_e           win
);

    always_comb begin
        win = EV_NONE;
        for (int i = NUM_EV - 1; i >= 0; i--) begin
            if (req[i]) begin
                win = rcu_ev_e'(4'(i + 1));
            end
        end
    end

    always_comb begin
        if (req[0]) begin
            assert (win == EV_POR) else $error("AST_POR_WINS violated"); // R9
        end
    end

endmodule

// File: rtl/rcu_flag_fsm.sv
module rcu_flag_fsm
    import rcu_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  rcu_ev_e ev,
    output logic    to_flag,
    output logic    pd_flag
);

    rcu_state_e state_q;
    rcu_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CLEAN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (ev)
            EV_POR, EV_MCLR_RUN, EV_WCLR: state_d = ST_CLEAN;
            EV_WDT_RUN:                   state_d = ST_WDT_RST;
            EV_MCLR_SLP, EV_IRQ, EV_SLEEP: state_d = ST_DOWN;
            EV_WDT_SLP:                   state_d = ST_WDT_WAKE;
            EV_NONE:                      state_d = state_q;
            default:                      state_d = state_q;
        endcase
    end

    always_comb begin
        to_flag = 1'b1;
        pd_flag = 1'b1;
        unique case (state_q)
            ST_CLEAN:    begin to_flag = 1'b1; pd_flag = 1'b1; end
            ST_WDT_RST:  begin to_flag = 1'b0; pd_flag = 1'b1; end
            ST_DOWN:     begin to_flag = 1'b1; pd_flag = 1'b0; end
            ST_WDT_WAKE: begin to_flag = 1'b0; pd_flag = 1'b0; end
            default:     begin to_flag = 1'b1; pd_flag = 1'b1; end
        endcase
    end

    AST_IDLE_HOLDS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_NONE) |=> $stable({to_flag, pd_flag})); // R12
    AST_WDT_WAKE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_WDT_SLP) |=> (!to_flag && !pd_flag)); // R5
    AST_SLEEP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_SLEEP) |=> (to_flag && !pd_flag)); // R8

endmodule

// File: rtl/rcu_bank_reg.sv
module rcu_bank_reg
    import rcu_pkg::*;
#(
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rcu_ev_e           ev,
    input  logic              we,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] bits
);

    logic [BANK_W-1:0] bits_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else if (ev_clears_bank(ev)) begin
            bits_q <= '0;
        end else if (ev == EV_NONE && we) begin
            bits_q <= wdata;
        end
    end

    assign bits = bits_q;

    AST_WAKE_KEEPS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        ev_is_wake(ev) |=> $stable(bits)); // R5
    AST_EVENT_BEATS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (ev != EV_NONE && !ev_clears_bank(ev)) |=> $stable(bits)); // R10

endmodule

// File: rtl/rcu_vector.sv
module rcu_vector
    import rcu_pkg::*;
#(
    parameter int          PC_W    = 13,
    parameter logic [31:0] IRQ_VEC = 32'h4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  rcu_ev_e         ev,
    input  logic            gie,
    input  logic [PC_W-1:0] cur_pc,
    output logic            pc_load,
    output logic [PC_W-1:0] pc_next
);

    localparam logic [PC_W-1:0] VEC = IRQ_VEC[PC_W-1:0];

    logic [PC_W-1:0] pc_d;
    logic [PC_W-1:0] pc_q;
    logic            load_q;

    always_comb begin
        pc_d = pc_q;
        if (ev_clears_bank(ev)) begin
            pc_d = '0;
        end else if (ev == EV_IRQ && gie) begin
            pc_d = VEC;
        end else if (ev_is_wake(ev)) begin
            pc_d = cur_pc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q   <= '0;
            load_q <= 1'b0;
        end else begin
            pc_q   <= pc_d;
            load_q <= ev_loads_pc(ev);
        end
    end

    assign pc_load = load_q;
    assign pc_next = pc_q;

    AST_LOAD_ONLY_AFTER_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_loads_pc(ev) |=> !pc_load); // R12
    AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_IRQ && gie) |=> (pc_load && pc_next == VEC)); // R7
    AST_RESET_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        ev_clears_bank(ev) |=> (pc_load && pc_next == '0)); // R2

endmodule

// File: rtl/rst_cause_unit.sv
module rst_cause_unit
    import rcu_pkg::*;
#(
    parameter int          PC_W    = 13,
    parameter int          BANK_W  = 3,
    parameter logic [31:0] IRQ_VEC = 32'h4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_por,
    input  logic              ev_mclr_run,
    input  logic              ev_mclr_slp,
    input  logic              ev_wdt_run,
    input  logic              ev_wdt_slp,
    input  logic              ev_irq_wake,
    input  logic              ev_sleep,
    input  logic              ev_wdt_clr,
    input  logic              gie,
    input  logic [PC_W-1:0]   cur_pc,
    input  logic              bank_we,
    input  logic [BANK_W-1:0] bank_wdata,
    output logic              to_flag,
    output logic              pd_flag,
    output logic [BANK_W-1:0] bank_bits,
    output logic              pc_load,
    output logic [PC_W-1:0]   pc_next
);

    logic [NUM_EV-1:0] req;
    rcu_ev_e           win;

    assign req = {ev_wdt_clr, ev_sleep, ev_irq_wake, ev_wdt_slp,
                  ev_wdt_run, ev_mclr_slp, ev_mclr_run, ev_por};

    rcu_arbiter u_arb (
        .req (req),
        .win (win)
    );

    rcu_flag_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (win),
        .to_flag (to_flag),
        .pd_flag (pd_flag)
    );

    rcu_bank_reg #(.BANK_W(BANK_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .ev    (win),
        .we    (bank_we),
        .wdata (bank_wdata),
        .bits  (bank_bits)
    );

    rcu_vector #(.PC_W(PC_W), .IRQ_VEC(IRQ_VEC)) u_vec (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (win),
        .gie     (gie),
        .cur_pc  (cur_pc),
        .pc_load (pc_load),
        .pc_next (pc_next)
    );

    AST_POR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_por |=> (to_flag && pd_flag && bank_bits == '0)); // R1
    AST_WDT_RUN_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_wdt_run && !ev_por && !ev_mclr_run && !ev_mclr_slp)
        |=> (!to_flag && pd_flag && bank_bits == '0)); // R4
    AST_MCLR_SLP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_mclr_slp && !ev_por && !ev_mclr_run)
        |=> (to_flag && !pd_flag && bank_bits == '0)); // R3

endmodule

// File: tb/rst_cause_unit_tb_top.sv
module rst_cause_unit_tb_top;

    localparam int PC_W   = 13;
    localparam int BANK_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [7:0]        evm = '0;
    logic              gie = 1'b0;
    logic [PC_W-1:0]   cur_pc = '0;
    logic              bank_we = 1'b0;
    logic [BANK_W-1:0] bank_wdata = '0;
    logic              to_flag, pd_flag, pc_load;
    logic [BANK_W-1:0] bank_bits;
    logic [PC_W-1:0]   pc_next;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    rst_cause_unit dut_i (
        .clk (clk), .rst_n (rst_n),
        .ev_por (evm[0]), .ev_mclr_run (evm[1]), .ev_mclr_slp (evm[2]),
        .ev_wdt_run (evm[3]), .ev_wdt_slp (evm[4]), .ev_irq_wake (evm[5]),
        .ev_sleep (evm[6]), .ev_wdt_clr (evm[7]),
        .gie (gie), .cur_pc (cur_pc),
        .bank_we (bank_we), .bank_wdata (bank_wdata),
        .to_flag (to_flag), .pd_flag (pd_flag), .bank_bits (bank_bits),
        .pc_load (pc_load), .pc_next (pc_next)
    );

    // Event mask bits
    localparam logic [7:0] M_POR = 8'h01, M_MCR = 8'h02, M_MCS = 8'h04,
                           M_WDR = 8'h08, M_WDS = 8'h10, M_IRQ = 8'h20,
                           M_SLP = 8'h40, M_CLR = 8'h80;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Checks flags, bank, load, pc after the cycle that saw the stimulus
    task automatic chk_all(input string req, input logic t, input logic p,
                           input logic [2:0] b, input logic ld, input logic [12:0] pc);
        chk(req, "to", 32'(to_flag), 32'(t));
        chk(req, "pd", 32'(pd_flag), 32'(p));
        chk(req, "bank", 32'(bank_bits), 32'(b));
        chk(req, "load", 32'(pc_load), 32'(ld));
        if (ld) chk(req, "pc", 32'(pc_next), 32'(pc));
    endtask

    task automatic fire(input logic [7:0] m, input logic g, input logic [12:0] pc);
        @(negedge clk);
        evm = m; gie = g; cur_pc = pc;
        @(negedge clk);
        evm = '0;
    endtask

    task automatic wr_bank(input logic [2:0] v);
        @(negedge clk);
        bank_we = 1'b1; bank_wdata = v;
        @(negedge clk);
        bank_we = 1'b0;
        chk("R10", "bank write", 32'(bank_bits), 32'(v));
    endtask

    task automatic t_reset;
        chk_all("R1", 1'b1, 1'b1, 3'd0, 1'b0, 13'd0);
        chk("R1", "pc after reset", 32'(pc_next), 32'd0);
    endtask

    task automatic t_por;
        wr_bank(3'd5);
        fire(M_POR, 1'b0, 13'h055);
        chk_all("R1", 1'b1, 1'b1, 3'd0, 1'b1, 13'd0);
    endtask

    task automatic t_mclr_run;
        wr_bank(3'd3);
        fire(M_MCR, 1'b1, 13'h100);
        chk_all("R2", 1'b1, 1'b1, 3'd0, 1'b1, 13'd0);
    endtask

    task automatic t_sleep_wdt_wake;
        wr_bank(3'd6);
        fire(M_SLP, 1'b0, 13'h122);
        chk_all("R8", 1'b1, 1'b0, 3'd6, 1'b0, 13'd0);
        fire(M_WDS, 1'b1, 13'h123);
        chk_all("R5", 1'b0, 1'b0, 3'd6, 1'b1, 13'h124);
        @(negedge clk);
        chk("R12", "load drops", 32'(pc_load), 32'd0);
        chk("R12", "pc holds", 32'(pc_next), 32'h124);
        chk("R12", "flags hold", 32'({to_flag, pd_flag}), 32'd0);
    endtask

    task automatic t_irq;
        fire(M_SLP, 1'b0, 13'h0);
        fire(M_IRQ, 1'b0, 13'h0FF);
        chk_all("R6", 1'b1, 1'b0, 3'd6, 1'b1, 13'h100);
        fire(M_SLP, 1'b0, 13'h0);
        fire(M_IRQ, 1'b1, 13'h0FF);
        chk_all("R7", 1'b1, 1'b0, 3'd6, 1'b1, 13'h004);
    endtask

    task automatic t_mclr_slp_wdt_run;
        fire(M_MCS, 1'b0, 13'h0AA);
        chk_all("R3", 1'b1, 1'b0, 3'd0, 1'b1, 13'd0);
        wr_bank(3'd2);
        fire(M_WDR, 1'b0, 13'h0AA);
        chk_all("R4", 1'b0, 1'b1, 3'd0, 1'b1, 13'd0);
        wr_bank(3'd4);
        fire(M_CLR, 1'b0, 13'h0AA);
        chk_all("R8", 1'b1, 1'b1, 3'd4, 1'b0, 13'd0);
    endtask

    task automatic t_wrap;
        fire(M_WDS, 1'b0, 13'h1FFF);
        chk_all("R11", 1'b0, 1'b0, 3'd4, 1'b1, 13'd0);
    endtask

    task automatic t_priority;
        fire(M_POR | M_WDR, 1'b0, 13'h10);
        chk_all("R9", 1'b1, 1'b1, 3'd0, 1'b1, 13'd0);
        wr_bank(3'd7);
        fire(M_MCS | M_WDS, 1'b0, 13'h10);
        chk_all("R9", 1'b1, 1'b0, 3'd0, 1'b1, 13'd0);
        wr_bank(3'd7);
        fire(M_WDR | M_WDS, 1'b0, 13'h10);
        chk_all("R9", 1'b0, 1'b1, 3'd0, 1'b1, 13'd0);
        wr_bank(3'd1);
        fire(M_WDS | M_IRQ, 1'b1, 13'h20);
        chk_all("R9", 1'b0, 1'b0, 3'd1, 1'b1, 13'h21);
        fire(M_IRQ | M_CLR, 1'b0, 13'h30);
        chk_all("R9", 1'b1, 1'b0, 3'd1, 1'b1, 13'h31);
        fire(M_SLP | M_CLR, 1'b0, 13'h30);
        chk_all("R9", 1'b1, 1'b0, 3'd1, 1'b0, 13'd0);
    endtask

    task automatic t_write_vs_event;
        wr_bank(3'd7);
        @(negedge clk);
        bank_we = 1'b1; bank_wdata = 3'd2; evm = M_MCR;
        @(negedge clk);
        bank_we = 1'b0; evm = '0;
        chk("R10", "clear beats write", 32'(bank_bits), 32'd0);
        @(negedge clk);
        bank_we = 1'b1; bank_wdata = 3'd5; evm = M_SLP;
        @(negedge clk);
        bank_we = 1'b0; evm = '0;
        chk("R10", "sleep drops write", 32'(bank_bits), 32'd0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                t_reset();
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_por();
                t_mclr_run();
                t_sleep_wdt_wake();
                t_irq();
                t_mclr_slp_wdt_run();
                t_wrap();
                t_priority();
                t_write_vs_event();
            end
            begin
                repeat (20000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule